// File: doc/BRIEF.md
# Downlink Command Frame Decoder

This block sits behind the envelope detector of a passive tag and turns the reader's downlink into commands. Its input is one sample per carrier clock saying whether the carrier is present. When the tag's uplink is in the modulated phase of a listen window, a carrier gap starts a bit frame and the decoder takes over. It asks the uplink to stop transmitting, checks that a second zero follows, and then decodes a 9-bit command and whatever argument frames that command carries.

A bit lasts 64 carrier periods at the slow rate and 32 at the fast rate. A zero is a carrier gap that starts early in the bit frame. A one is an unbroken carrier. Frames are counted from the first gap, so once receive mode has begun the reader sets the timing.

A decoded command leaves on a valid/ready stream as one beat that carries the command code, up to two 32-bit arguments and a word address. The beat holds with stable fields until the consumer takes it. While a beat is pending, the decoder ignores new receive-mode entries, because the air interface cannot be stalled. Back-pressure therefore only delays the next downlink session. It never drops or overwrites a result. Framing, parity and stop-bit faults pulse `frame_err`. A well-formed but unknown command code pulses `cmd_err`. After a fault the decoder goes back to idle.

Top module: `cfd_decoder`

## Requirements
- R1: After reset, `halt_tx`, `out_valid`, `frame_err` and `cmd_err` are all 0.
- R2: A bit lasts 64 carrier periods when `rate_fast`=0 and 32 when `rate_fast`=1. The bit is 0 if the carrier is absent in any sample among the first LATE+1 periods of the frame (LATE=7 slow, 4 fast). A gap that starts later in the frame reads as 1.
- R3: In idle, a sample with the carrier absent while `lw_mod_on`=1 starts the first bit frame at that sample. `halt_tx` rises on the next cycle and stays high until receive mode ends. The second bit must also be 0, otherwise `frame_err` pulses.
- R4: A carrier gap while `lw_mod_on`=0 in idle has no effect: `halt_tx` stays 0 and no error is reported.
- R5: A command block is 9 bits. The first bit received is the MSB of the 8-bit code, and the ninth bit makes the number of ones in the block even. A parity fault pulses `frame_err`.
- R6: These codes, written first-received bit first, are accepted and reported on `out_cmd`: 00000001 gives 1 (login, one data frame), 00010001 gives 2 (password change, two data frames), 00010100 gives 3 (word write, address block plus one data frame), 00001010 gives 4 (area read, one data frame), 10000000 gives 5 (reset, no argument).
- R7: A code not listed in R6 that has correct parity pulses `cmd_err`, produces no `out_valid`, and returns the decoder to idle.
- R8: A data frame is four row blocks, each 8 bits plus even parity, with word bit 31 received first. A fifth block follows: 8 column-parity bits equal to the XOR of the four row bytes (MSB first), then a 0 stop bit. Any row-parity, column-parity or stop-bit mismatch pulses `frame_err`.
- R9: The address block of a word write is 8 bits plus even parity. Its first three bits received must be 0, and its last six data bits become `out_addr`. A violation pulses `frame_err`.
- R10: For an area read, `out_arg0` carries word bits 15:0 (first address in 7:0, last address in 15:8). Bits 31:16 are received but reported as 0.
- R11: For a password change, `out_arg0` is the first data frame and `out_arg1` the second. For login and word write, `out_arg0` is the data frame. All unused argument fields are 0.
- R12: `out_valid` and all `out_*` fields hold stable until `out_ready` is high. While a beat is pending, `halt_tx` stays 0 and entry conditions are ignored.
- R13: After a completed command or any error, `halt_tx` is 0 and a new entry is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-derived clock, one cycle per carrier period |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_fast | input | 1 | 1 selects the 32-period bit, 0 the 64-period bit |
| carrier_in | input | 1 | 1 when the carrier is present in this period |
| lw_mod_on | input | 1 | High during the modulated phase of an uplink listen window |
| halt_tx | output | 1 | Request to stop uplink transmission while receiving |
| out_valid | output | 1 | Decoded command beat available |
| out_ready | input | 1 | Consumer accepts the beat |
| out_cmd | output | 3 | Command code as listed in R6 |
| out_arg0 | output | 32 | First argument word |
| out_arg1 | output | 32 | Second argument word |
| out_addr | output | 6 | Word address of a word write |
| frame_err | output | 1 | One-cycle pulse on a framing, parity or stop-bit fault |
| cmd_err | output | 1 | One-cycle pulse on an unknown command code |

## Verification
A bit is sliced on the last carrier period of its frame, and `bit_valid` follows one cycle later. A fault in a sync bit is reported on the cycle after that. Any result that comes from a 9-bit block (a decoded beat, a parity, address or stop fault, or an unknown code) is due two cycles after the last period of the block's final bit. `halt_tx` rises one cycle after the entry sample. The bench uses a monitor that counts result pulses and captures the rising edge of `out_valid` on every falling clock edge. Each scenario then allows an eight-cycle settling window past the final bit before it compares counter deltas and captured fields. That window covers every due cycle above, and it ends before the next scenario can start a new entry.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

  localparam int CODE_W = 8;

  typedef enum logic [2:0] {
    CMD_NONE  = 3'd0,
    CMD_LOGIN = 3'd1,
    CMD_PWCHG = 3'd2,
    CMD_WWORD = 3'd3,
    CMD_AREAD = 3'd4,
    CMD_RESET = 3'd5
  } cmd_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SYNC,
    S_CMD,
    S_ADDR,
    S_DATA,
    S_OUT
  } st_e;

  function automatic cmd_e decode_code(input logic [CODE_W-1:0] code);
    case (code)
      8'b0000_0001: decode_code = CMD_LOGIN;
      8'b0001_0001: decode_code = CMD_PWCHG;
      8'b0001_0100: decode_code = CMD_WWORD;
      8'b0000_1010: decode_code = CMD_AREAD;
      8'b1000_0000: decode_code = CMD_RESET;
      default:      decode_code = CMD_NONE;
    endcase
  endfunction

endpackage

// File: rtl/cfd_bit_slicer.sv
module cfd_bit_slicer #(
  parameter int SLOW_BIT  = 64,
  parameter int FAST_BIT  = 32,
  parameter int SLOW_LATE = 7,
  parameter int FAST_LATE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_fast,
  input  logic carrier,
  input  logic start,
  input  logic run,
  output logic bit_valid,
  output logic bit_val
);
  localparam int CW = $clog2(SLOW_BIT);
  localparam logic [CW-1:0] SLOW_END = CW'(SLOW_BIT - 1);
  localparam logic [CW-1:0] FAST_END = CW'(FAST_BIT - 1);
  localparam logic [CW-1:0] SLOW_LIM = CW'(SLOW_LATE);
  localparam logic [CW-1:0] FAST_LIM = CW'(FAST_LATE);

  logic [CW-1:0] cnt;
  logic [CW-1:0] frame_end;
  logic [CW-1:0] late_lim;
  logic          zero_seen;
  logic          early;

  always_comb begin
    frame_end = rate_fast ? FAST_END : SLOW_END;
    late_lim  = rate_fast ? FAST_LIM : SLOW_LIM;
    early     = (cnt <= late_lim);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      zero_seen <= 1'b0;
      bit_valid <= 1'b0;
      bit_val   <= 1'b0;
    end else begin
      bit_valid <= 1'b0;
      if (start) begin
        // the entry sample is frame period 0 and already a gap
        cnt       <= CW'(1);
        zero_seen <= 1'b1;
      end else if (run) begin
        if (cnt == frame_end) begin
          cnt       <= '0;
          zero_seen <= 1'b0;
          bit_valid <= 1'b1;
          bit_val   <= ~zero_seen;
        end else begin
          cnt <= cnt + CW'(1);
          if (early && !carrier) zero_seen <= 1'b1;
        end
      end else begin
        cnt       <= '0;
        zero_seen <= 1'b0;
      end
    end
  end

  // R2: one slice per frame, never on back-to-back cycles
  p_bit_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid);

  // R2: a gap seen early in a running frame is remembered or sliced
  p_gap_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && early && !carrier && cnt != frame_end) |=> (zero_seen || !run));

endmodule

// File: rtl/cfd_block_collect.sv
module cfd_block_collect #(
  parameter int BLK_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             bit_valid,
  input  logic             bit_val,
  output logic             blk_valid,
  output logic [BLK_W-1:0] blk,
  output logic             blk_par_ok
);
  localparam int NW = $clog2(BLK_W + 1);
  localparam logic [NW-1:0] LAST = NW'(BLK_W - 1);

  logic [NW-1:0]    n;
  logic [BLK_W-2:0] sh;

  assign blk_par_ok = ~(^blk);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n         <= '0;
      sh        <= '0;
      blk       <= '0;
      blk_valid <= 1'b0;
    end else begin
      blk_valid <= 1'b0;
      if (!en) begin
        n <= '0;
      end else if (bit_valid) begin
        sh <= {sh[BLK_W-3:0], bit_val};
        if (n == LAST) begin
          blk       <= {sh, bit_val};
          blk_valid <= 1'b1;
          n         <= '0;
        end else begin
          n <= n + NW'(1);
        end
      end
    end
  end

  // R5: a block is reported once per nine bits, never twice in a row
  p_blk_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |=> !blk_valid);

endmodule

// File: rtl/cfd_decoder.sv
module cfd_decoder
  import cfd_pkg::*;
#(
  parameter int SLOW_BIT  = 64,
  parameter int FAST_BIT  = 32,
  parameter int SLOW_LATE = 7,
  parameter int FAST_LATE = 4,
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rate_fast,
  input  logic              carrier_in,
  input  logic              lw_mod_on,
  output logic              halt_tx,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_cmd,
  output logic [WORD_W-1:0] out_arg0,
  output logic [WORD_W-1:0] out_arg1,
  output logic [ADDR_W-1:0] out_addr,
  output logic              frame_err,
  output logic              cmd_err
);
  localparam int BLK_W = CODE_W + 1;
  localparam int ROWS  = WORD_W / CODE_W;
  localparam int RW    = $clog2(ROWS + 1);
  localparam logic [RW-1:0] COL_ROW = RW'(ROWS);
  localparam logic [WORD_W-1:0] AREA_MASK =
    {{(WORD_W - 2*CODE_W){1'b0}}, {(2*CODE_W){1'b1}}};

  st_e               state;
  logic              sync_second;
  logic [RW-1:0]     row;
  logic              more;
  cmd_e              cmd_q;
  cmd_e              dec;
  logic [WORD_W-1:0] acc;
  logic [CODE_W-1:0] col;
  logic              start;
  logic              bit_valid, bit_val;
  logic              blk_valid, blk_par_ok;
  logic [BLK_W-1:0]  blk;
  logic [CODE_W-1:0] byte_v;
  logic              coll_en;

  assign start     = (state == S_IDLE) && lw_mod_on && !carrier_in;
  assign halt_tx   = (state == S_SYNC) || (state == S_CMD) ||
                     (state == S_ADDR) || (state == S_DATA);
  assign coll_en   = (state == S_CMD) || (state == S_ADDR) || (state == S_DATA);
  assign out_valid = (state == S_OUT);
  assign out_cmd   = cmd_q;
  assign byte_v    = blk[BLK_W-1:1];
  assign dec       = decode_code(byte_v);

  cfd_bit_slicer #(
    .SLOW_BIT(SLOW_BIT), .FAST_BIT(FAST_BIT),
    .SLOW_LATE(SLOW_LATE), .FAST_LATE(FAST_LATE)
  ) u_slicer (
    .clk(clk), .rst_n(rst_n), .rate_fast(rate_fast), .carrier(carrier_in),
    .start(start), .run(halt_tx), .bit_valid(bit_valid), .bit_val(bit_val)
  );

  cfd_block_collect #(.BLK_W(BLK_W)) u_collect (
    .clk(clk), .rst_n(rst_n), .en(coll_en), .bit_valid(bit_valid),
    .bit_val(bit_val), .blk_valid(blk_valid), .blk(blk), .blk_par_ok(blk_par_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      sync_second <= 1'b0;
      row         <= '0;
      more        <= 1'b0;
      cmd_q       <= CMD_NONE;
      acc         <= '0;
      col         <= '0;
      out_arg0    <= '0;
      out_arg1    <= '0;
      out_addr    <= '0;
      frame_err   <= 1'b0;
      cmd_err     <= 1'b0;
    end else begin
      frame_err <= 1'b0;
      cmd_err   <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state       <= S_SYNC;
          sync_second <= 1'b0;
        end
        S_SYNC: if (bit_valid) begin
          if (!sync_second) begin
            sync_second <= 1'b1;
          end else if (bit_val) begin
            frame_err <= 1'b1;
            state     <= S_IDLE;
          end else begin
            state <= S_CMD;
          end
        end
        S_CMD: if (blk_valid) begin
          if (!blk_par_ok) begin
            frame_err <= 1'b1;
            state     <= S_IDLE;
          end else if (dec == CMD_NONE) begin
            cmd_err <= 1'b1;
            state   <= S_IDLE;
          end else begin
            cmd_q    <= dec;
            out_arg0 <= '0;
            out_arg1 <= '0;
            out_addr <= '0;
            row      <= '0;
            col      <= '0;
            more     <= (dec == CMD_PWCHG);
            if (dec == CMD_RESET)      state <= S_OUT;
            else if (dec == CMD_WWORD) state <= S_ADDR;
            else                       state <= S_DATA;
          end
        end
        S_ADDR: if (blk_valid) begin
          if (!blk_par_ok || (blk[BLK_W-1:ADDR_W] != '0)) begin
            frame_err <= 1'b1;
            state     <= S_IDLE;
          end else begin
            out_addr <= blk[ADDR_W:1];
            state    <= S_DATA;
          end
        end
        S_DATA: if (blk_valid) begin
          if (row != COL_ROW) begin
            if (!blk_par_ok) begin
              frame_err <= 1'b1;
              state     <= S_IDLE;
            end else begin
              acc <= {acc[WORD_W-CODE_W-1:0], byte_v};
              col <= col ^ byte_v;
              row <= row + RW'(1);
            end
          end else if ((byte_v != col) || blk[0]) begin
            frame_err <= 1'b1;
            state     <= S_IDLE;
          end else begin
            row <= '0;
            col <= '0;
            if (more) begin
              more     <= 1'b0;
              out_arg0 <= acc;
            end else begin
              case (cmd_q)
                CMD_PWCHG: out_arg1 <= acc;
                CMD_AREAD: out_arg0 <= acc & AREA_MASK;
                default:   out_arg0 <= acc;
              endcase
              state <= S_OUT;
            end
          end
        end
        S_OUT: if (out_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3: an accepted entry raises the uplink halt on the next cycle
  p_halt_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> halt_tx);

  // R12: a stalled beat keeps all of its fields
  p_hold_beat_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_cmd) &&
      $stable(out_arg0) && $stable(out_arg1) && $stable(out_addr)));

  // R12: no receive session while a beat is pending
  p_no_halt_pending_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(halt_tx && out_valid));

  // R7: the two fault kinds never coincide
  p_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_err && cmd_err));

  // R13: a fault always leaves receive mode
  p_err_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err || cmd_err) |-> (!halt_tx && !out_valid));

endmodule

// File: tb/tb_cfd_decoder.sv
`timescale 1ns/1ps
module tb_cfd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rate_fast = 1'b0;
  logic        carrier_in = 1'b1;
  logic        lw_mod_on = 1'b0;
  logic        out_ready = 1'b1;
  logic        halt_tx, out_valid, frame_err, cmd_err;
  logic [2:0]  out_cmd;
  logic [31:0] out_arg0, out_arg1;
  logic [5:0]  out_addr;

  int total = 0;
  int bad = 0;
  int ov_cnt = 0, fe_cnt = 0, ce_cnt = 0;
  logic        ov_prev = 1'b0;
  logic [2:0]  cap_cmd = '0;
  logic [31:0] cap_a0 = '0, cap_a1 = '0;
  logic [5:0]  cap_addr = '0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  cfd_decoder dut (
    .clk(clk), .rst_n(rst_n), .rate_fast(rate_fast), .carrier_in(carrier_in),
    .lw_mod_on(lw_mod_on), .halt_tx(halt_tx), .out_valid(out_valid),
    .out_ready(out_ready), .out_cmd(out_cmd), .out_arg0(out_arg0),
    .out_arg1(out_arg1), .out_addr(out_addr), .frame_err(frame_err),
    .cmd_err(cmd_err)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && !ov_prev) begin
        ov_cnt++;
        cap_cmd = out_cmd; cap_a0 = out_arg0; cap_a1 = out_arg1; cap_addr = out_addr;
      end
      if (frame_err) fe_cnt++;
      if (cmd_err) ce_cnt++;
    end
    ov_prev = out_valid;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int per();
    return rate_fast ? 32 : 64;
  endfunction

  function automatic int late();
    return rate_fast ? 4 : 7;
  endfunction

  // gap from frame period off up to half the bit; off<0 means no gap
  task automatic send_gap(input int off);
    for (int k = 0; k < per(); k++) begin
      @(negedge clk);
      carrier_in = !(off >= 0 && k >= off && k < per()/2);
    end
  endtask

  task automatic send_bit(input bit b);
    send_gap(b ? -1 : 0);
  endtask

  task automatic send_blk(input logic [7:0] b, input bit flip);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    send_bit((^b) ^ flip);
  endtask

  // mode: 0 good, 1 bad row parity, 2 bad column parity, 3 stop bit high
  task automatic send_word(input logic [31:0] w, input int mode);
    logic [7:0] c = '0;
    for (int r = 0; r < 4; r++) begin
      logic [7:0] rb = w[31-8*r -: 8];
      c ^= rb;
      send_blk(rb, (mode == 1) && (r == 1));
    end
    if (mode == 2) c ^= 8'h10;
    for (int i = 7; i >= 0; i--) send_bit(c[i]);
    send_bit(mode == 3);
  endtask

  task automatic entry(input int second_off);
    lw_mod_on = 1'b1;
    send_bit(1'b0);
    lw_mod_on = 1'b0;
    send_gap(second_off);
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic expect_counts(input string tag, input int ov0, input int fe0, input int ce0,
                               input int dov, input int dfe, input int dce);
    chk(ov_cnt - ov0 == dov, {tag, " beats"}, 64'(ov_cnt - ov0), 64'(dov));
    chk(fe_cnt - fe0 == dfe, {tag, " frame_err"}, 64'(fe_cnt - fe0), 64'(dfe));
    chk(ce_cnt - ce0 == dce, {tag, " cmd_err"}, 64'(ce_cnt - ce0), 64'(dce));
    chk(halt_tx == 1'b0, {tag, " R13 halt after end"}, 64'(halt_tx), 64'd0);
  endtask

  task automatic expect_beat(input string tag, input logic [2:0] c, input logic [31:0] a0,
                             input logic [31:0] a1, input logic [5:0] ad);
    chk(cap_cmd == c, {tag, " cmd"}, 64'(cap_cmd), 64'(c));
    chk(cap_a0 == a0, {tag, " arg0"}, 64'(cap_a0), 64'(a0));
    chk(cap_a1 == a1, {tag, " arg1"}, 64'(cap_a1), 64'(a1));
    chk(cap_addr == ad, {tag, " addr"}, 64'(cap_addr), 64'(ad));
  endtask

  task automatic good_cmds(input string rt);
    int o, f, c;
    logic [31:0] w1, w2;
    w1 = rate_fast ? 32'h3C5A_9601 : 32'hA5C3_0F96;
    w2 = rate_fast ? 32'h0FF0_1234 : 32'h7E81_C3DB;
    o = ov_cnt; f = fe_cnt; c = ce_cnt;
    entry(0);
    chk(halt_tx == 1'b1, {rt, " R3 halt during receive"}, 64'(halt_tx), 64'd1);
    send_blk(8'h80, 1'b0); settle();
    expect_counts({rt, " R6 reset"}, o, f, c, 1, 0, 0);
    expect_beat({rt, " R6 reset"}, 3'd5, 32'd0, 32'd0, 6'd0);

    o = ov_cnt;
    entry(0); send_blk(8'h01, 1'b0); send_word(w1, 0); settle();
    expect_counts({rt, " R8 login"}, o, f, c, 1, 0, 0);
    expect_beat({rt, " R11 login"}, 3'd1, w1, 32'd0, 6'd0);

    o = ov_cnt;
    entry(0); send_blk(8'h11, 1'b0); send_word(w1, 0); send_word(w2, 0); settle();
    expect_counts({rt, " R11 pwchg"}, o, f, c, 1, 0, 0);
    expect_beat({rt, " R11 pwchg"}, 3'd2, w1, w2, 6'd0);

    o = ov_cnt;
    entry(0); send_blk(8'h14, 1'b0); send_blk(8'h13, 1'b0); send_word(w2, 0); settle();
    expect_counts({rt, " R9 wword"}, o, f, c, 1, 0, 0);
    expect_beat({rt, " R9 wword"}, 3'd3, w2, 32'd0, 6'h13);

    o = ov_cnt;
    entry(0); send_blk(8'h0A, 1'b0); send_word(w1, 0); settle();
    expect_counts({rt, " R10 aread"}, o, f, c, 1, 0, 0);
    expect_beat({rt, " R10 aread"}, 3'd4, {16'd0, w1[15:0]}, 32'd0, 6'd0);
  endtask

  task automatic fault_cases(input string rt);
    int o, f, c;
    o = ov_cnt; f = fe_cnt; c = ce_cnt;
    entry(0); send_blk(8'h01, 1'b1); settle();
    expect_counts({rt, " R5 cmd parity"}, o, f, c, 0, 1, 0);
    f = fe_cnt;
    entry(0); send_blk(8'h01, 1'b0); send_word(32'h1357_9BDF, 1); settle();
    expect_counts({rt, " R8 row parity"}, o, f, c, 0, 1, 0);
    f = fe_cnt;
    entry(0); send_blk(8'h01, 1'b0); send_word(32'h1357_9BDF, 2); settle();
    expect_counts({rt, " R8 column parity"}, o, f, c, 0, 1, 0);
    f = fe_cnt;
    entry(0); send_blk(8'h01, 1'b0); send_word(32'h1357_9BDF, 3); settle();
    expect_counts({rt, " R8 stop bit"}, o, f, c, 0, 1, 0);
    f = fe_cnt;
    entry(0); send_blk(8'h14, 1'b0); send_blk(8'h23, 1'b0); send_word(32'h1, 0); settle();
    expect_counts({rt, " R9 address bit5"}, o, f, c, 0, 1, 0);
    f = fe_cnt;
    entry(0); send_blk(8'h14, 1'b0); send_blk(8'h80, 1'b0); send_word(32'h1, 0); settle();
    expect_counts({rt, " R9 address bit7"}, o, f, c, 0, 1, 0);
    f = fe_cnt;
    entry(-1); settle();
    expect_counts({rt, " R3 second bit one"}, o, f, c, 0, 1, 0);
    f = fe_cnt;
    entry(late() + 1); settle();
    expect_counts({rt, " R2 late gap reads one"}, o, f, c, 0, 1, 0);
    f = fe_cnt;
    entry(late()); send_blk(8'h80, 1'b0); settle();
    expect_counts({rt, " R2 gap at limit reads zero"}, o, f, c, 1, 0, 0);
  endtask

  initial begin
    int o, f, c;
    repeat (4) @(negedge clk);
    chk(halt_tx == 1'b0 && out_valid == 1'b0 && frame_err == 1'b0 && cmd_err == 1'b0,
        "R1 reset state", {halt_tx, out_valid, frame_err, cmd_err}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R4: gap outside a listen window
    o = ov_cnt; f = fe_cnt; c = ce_cnt;
    send_bit(1'b0); send_bit(1'b0);
    chk(halt_tx == 1'b0, "R4 halt stays low", 64'(halt_tx), 64'd0);
    settle();
    expect_counts("R4 ignored gap", o, f, c, 0, 0, 0);

    rate_fast = 1'b0;
    good_cmds("slow");
    fault_cases("slow");
    rate_fast = 1'b1;
    good_cmds("fast");
    fault_cases("fast");

    // R12: stalled beat holds and blocks entry
    o = ov_cnt;
    out_ready = 1'b0;
    entry(0); send_blk(8'h80, 1'b0); settle();
    chk(out_valid == 1'b1 && out_cmd == 3'd5, "R12 beat held", {out_valid, out_cmd}, {1'b1, 3'd5});
    lw_mod_on = 1'b1; send_bit(1'b0); lw_mod_on = 1'b0;
    chk(halt_tx == 1'b0, "R12 entry ignored while pending", 64'(halt_tx), 64'd0);
    chk(out_valid == 1'b1 && out_cmd == 3'd5, "R12 fields stable", {out_valid, out_cmd}, {1'b1, 3'd5});
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R12 beat taken", 64'(out_valid), 64'd0);
    chk(ov_cnt - o == 1, "R12 single beat", 64'(ov_cnt - o), 64'd1);
    o = ov_cnt;
    entry(0); send_blk(8'h80, 1'b0); settle();
    chk(ov_cnt - o == 1, "R13 entry accepted again", 64'(ov_cnt - o), 64'd1);

    // R7: sweep of codes with correct parity that are not in the command set
    for (int i = 0; i < 86; i++) begin
      logic [7:0] code = 8'(3 * i);
      bit known = (code == 8'h01) || (code == 8'h11) || (code == 8'h14) ||
                  (code == 8'h0A) || (code == 8'h80);
      if (!known) begin
        o = ov_cnt; f = fe_cnt; c = ce_cnt;
        entry(0); send_blk(code, 1'b0); settle();
        chk(ce_cnt - c == 1 && ov_cnt == o && fe_cnt == f, "R7 unknown code",
            64'(code), 64'h100 | 64'(code));
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule